// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog that resets a system whose software has stopped running. A free-running prescaler counts crystal clock cycles. Its wrap from all ones to zero is a tick that advances a small watchdog counter. If the watchdog counter overflows, the block sends a single-cycle timeout pulse to the reset controller. Software keeps the system alive by writing any data value to one fixed service address on a simple write bus. That write clears the watchdog counter. It also clears the upper part of the prescaler, while the lowest prescaler bits keep counting.

Timeouts can be suppressed only by a combinational condition on test-mode inputs. That condition is an elevated voltage on the reset pin or the interrupt pin while the device is in monitor mode, or an elevated voltage on the reset pin while the device is in a break state. The block holds no stored bit that can turn the watchdog off. The voltage detection itself lies outside the block and reaches it as digital flags. With the default parameters, a timeout comes 64 prescaler periods of 8192 cycles after the last service.

Top module: `wdt_cop_top`

## Requirements
- R1: A write with `wr_en` high and `wr_addr` equal to `SVC_ADDR` (default 16'hFFFF) services the watchdog, whatever the value on `wr_data`, and sets the watchdog counter to zero.
- R2: A service write clears prescaler bits `PRE_W-1` down to `KEEP_W`. The low `KEEP_W` bits advance by one, as they do on any other cycle, with the carry out of the field discarded. The next tick therefore comes `2^PRE_W - L` cycles after the service edge, where L is the low field just after that edge.
- R3: A write to any other address, or a cycle with `wr_en` low, has no effect on either counter.
- R4: Without service and without disable, the first timeout pulse is visible right after clock edge number `2^(PRE_W+COP_W)` counted from reset release.
- R5: `cop_timeout` is high for exactly one cycle. Both counters are zero after the pulse, so the next pulse follows a full `2^(PRE_W+COP_W)` cycles later.
- R6: When `mon_mode` is high and either `hv_rst` or `hv_irq` is high, an overflow produces no pulse. Counting goes on, and the counters wrap to zero as usual.
- R7: When `brk_state` and `hv_rst` are both high, an overflow produces no pulse. `brk_state` together with `hv_irq` alone does not suppress the pulse, and neither does `mon_mode` without a high-voltage flag.
- R8: The disable is combinational. Only its value in the overflow cycle matters, and a disable that is removed before that cycle leaves no trace.
- R9: A service write in the same cycle as an overflow wins: no pulse is sent, and the counters restart as described in R1 and R2.
- R10: While `rst_n` is low, both counters are cleared and `cop_timeout` is low. A reset in mid-count restarts the full timeout interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data (value ignored) |
| hv_rst | input | 1 | Elevated voltage detected on the reset pin |
| hv_irq | input | 1 | Elevated voltage detected on the interrupt pin |
| mon_mode | input | 1 | Device is in monitor mode |
| brk_state | input | 1 | Device is in a break state |
| cop_timeout | output | 1 | One-cycle timeout pulse to the reset controller |

## Verification
The bench builds the block with `PRE_W=6`, `KEEP_W=2` and `COP_W=3`, which gives a 64-cycle tick and a 512-cycle timeout. That is short enough to reach first and second overflows, disabled wraps and service-versus-overflow collisions many times in one run. Keeping two low prescaler bits lets service edges with different low-field values shift the expected timeout by a few cycles, which shows that the low bits keep counting through a service. Overflow collisions are hit by placing a service write exactly on the overflow edge and on a tick edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    // Disable qualification: monitor mode with either high-voltage flag,
    // or break state with the reset-pin flag.
    function automatic logic hv_disable(input logic hv_rst,
                                        input logic hv_irq,
                                        input logic mon_mode,
                                        input logic brk_state);
        return (mon_mode & (hv_rst | hv_irq)) | (brk_state & hv_rst);
    endfunction

    // Selects which path made the disable true (for internal visibility).
    typedef enum logic [1:0] {
        WDT_ON      = 2'd0,
        WDT_OFF_MON = 2'd1,
        WDT_OFF_BRK = 2'd2
    } wdt_gate_e;

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W  = 13,
    parameter int KEEP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc,
    output logic [PRE_W-1:0] cnt,
    output logic             tick
);
    localparam int HI_W = PRE_W - KEEP_W;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;
    logic [PRE_W-1:0] svc_val;

    generate
        if (KEEP_W == 0) begin : g_clear_all
            assign svc_val = '0;
        end else begin : g_keep_low
            logic [KEEP_W-1:0] low_inc;
            assign low_inc = st_q.cnt[KEEP_W-1:0] + 1'b1;
            assign svc_val = {{HI_W{1'b0}}, low_inc};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (svc) begin
            st_d.cnt = svc_val;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign tick = &st_q.cnt;

endmodule

// File: rtl/wdt_cop_counter.sv
module wdt_cop_counter #(
    parameter int COP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             svc,
    input  logic             tick,
    output logic [COP_W-1:0] cnt,
    output logic             ovf
);
    typedef struct packed {
        logic [COP_W-1:0] cnt;
    } cop_st_t;

    cop_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (svc) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;
    assign ovf = tick & (&st_q.cnt) & ~svc;

endmodule

// File: rtl/wdt_disable_qual.sv
module wdt_disable_qual
    import wdt_pkg::*;
(
    input  logic      hv_rst,
    input  logic      hv_irq,
    input  logic      mon_mode,
    input  logic      brk_state,
    output logic      off,
    output wdt_gate_e gate
);
    always_comb begin
        off = hv_disable(hv_rst, hv_irq, mon_mode, brk_state);
        if (mon_mode & (hv_rst | hv_irq)) begin
            gate = WDT_OFF_MON;
        end else if (brk_state & hv_rst) begin
            gate = WDT_OFF_BRK;
        end else begin
            gate = WDT_ON;
        end
    end

endmodule

// File: rtl/wdt_cop_top.sv
module wdt_cop_top
    import wdt_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 16'hFFFF,
    parameter int              PRE_W    = 13,
    parameter int              KEEP_W   = 4,
    parameter int              COP_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              hv_rst,
    input  logic              hv_irq,
    input  logic              mon_mode,
    input  logic              brk_state,
    output logic              cop_timeout
);
    typedef struct packed {
        logic pulse;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             svc;
    logic [PRE_W-1:0] pre_cnt;
    logic             pre_tick;
    logic [COP_W-1:0] cop_cnt;
    logic             cop_ovf;
    logic             cop_off;
    wdt_gate_e        cop_gate;

    // Any data value services the watchdog; only strobe and address count.
    assign svc = wr_en && (wr_addr == SVC_ADDR);

    wdt_prescaler #(
        .PRE_W  (PRE_W),
        .KEEP_W (KEEP_W)
    ) u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .svc  (svc),
        .cnt  (pre_cnt),
        .tick (pre_tick)
    );

    wdt_cop_counter #(
        .COP_W(COP_W)
    ) u_cop (
        .clk  (clk),
        .rst_n(rst_n),
        .svc  (svc),
        .tick (pre_tick),
        .cnt  (cop_cnt),
        .ovf  (cop_ovf)
    );

    wdt_disable_qual u_qual (
        .hv_rst   (hv_rst),
        .hv_irq   (hv_irq),
        .mon_mode (mon_mode),
        .brk_state(brk_state),
        .off      (cop_off),
        .gate     (cop_gate)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pulse = cop_ovf & ~cop_off;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cop_timeout = st_q.pulse;

endmodule

// File: rtl/wdt_cop_chk.sv
module wdt_cop_chk #(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] SVC_ADDR = 16'hFFFF,
    parameter int              PRE_W    = 13,
    parameter int              KEEP_W   = 4,
    parameter int              COP_W    = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              hv_rst,
    input logic              hv_irq,
    input logic              mon_mode,
    input logic              brk_state,
    input logic              cop_timeout,
    input logic [PRE_W-1:0]  pre_q,
    input logic [COP_W-1:0]  cop_q
);
    logic hit;
    logic off_chk;
    assign hit     = wr_en && (wr_addr == SVC_ADDR);
    assign off_chk = (mon_mode && (hv_rst || hv_irq)) || (brk_state && hv_rst);

    // R1: a service write leaves the watchdog counter at zero
    p_svc_clears_cop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cop_q == '0));

    // R2: a service write leaves the upper prescaler field at zero
    p_svc_clears_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (pre_q[PRE_W-1:KEEP_W] == '0));

    // R5: the pulse lasts one cycle
    p_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cop_timeout |=> !cop_timeout);

    // R5: both counters restart from zero when the pulse appears
    p_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cop_timeout) |-> (cop_q == '0 && pre_q == '0));

    // R6 R7 R8: a disable in any cycle blocks a pulse in the next
    p_off_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        off_chk |=> !cop_timeout);

    // R9: service wins over an overflow in the same cycle
    p_svc_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !cop_timeout);

    // R3: without a service write the watchdog counter never drops except on wrap
    p_no_spurious_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && cop_q != '0 && !(&cop_q)) |=> (cop_q >= $past(cop_q)));

endmodule

bind wdt_cop_top wdt_cop_chk #(
    .ADDR_W  (ADDR_W),
    .SVC_ADDR(SVC_ADDR),
    .PRE_W   (PRE_W),
    .KEEP_W  (KEEP_W),
    .COP_W   (COP_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .hv_rst     (hv_rst),
    .hv_irq     (hv_irq),
    .mon_mode   (mon_mode),
    .brk_state  (brk_state),
    .cop_timeout(cop_timeout),
    .pre_q      (pre_cnt),
    .cop_q      (cop_cnt)
);

// File: tb/wdt_cop_top_tb_top.sv
module wdt_cop_top_tb_top;
    localparam int PRE_W  = 6;
    localparam int KEEP_W = 2;
    localparam int COP_W  = 3;
    localparam int PERIOD = 1 << PRE_W;
    localparam int FULL   = 1 << (PRE_W + COP_W);
    localparam logic [15:0] SVC = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        hv_rst = 1'b0;
    logic        hv_irq = 1'b0;
    logic        mon_mode = 1'b0;
    logic        brk_state = 1'b0;
    logic        cop_timeout;

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    wdt_cop_top #(
        .ADDR_W(16), .DATA_W(8), .SVC_ADDR(SVC),
        .PRE_W(PRE_W), .KEEP_W(KEEP_W), .COP_W(COP_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hv_rst(hv_rst), .hv_irq(hv_irq),
        .mon_mode(mon_mode), .brk_state(brk_state), .cop_timeout(cop_timeout)
    );

    // Vector: {en, addr[15:0], data[7:0], service edge[15:0]}
    localparam int NV = 8;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 16'hFFFF, 8'h00, 16'd10},
        {1'b1, 16'hFFFF, 8'hA5, 16'd13},
        {1'b1, 16'hFFFF, 8'hFF, 16'd63},
        {1'b1, 16'hFFFF, 8'h3C, 16'd64},
        {1'b1, 16'hFFFF, 8'h01, 16'd301},
        {1'b1, 16'hFFFF, 8'h80, 16'd450},
        {1'b1, 16'hFFFE, 8'h00, 16'd200},
        {1'b0, 16'hFFFF, 8'h00, 16'd200}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        n++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
    endtask

    task automatic write_at(input int edge_no, input bit en, input logic [15:0] a,
                            input logic [7:0] d);
        while (n < edge_no - 1) step();
        wr_en = en; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_addr = '0;
    endtask

    // Advance until a pulse is seen; returns the edge index, or -1 at limit.
    task automatic wait_pulse(input int limit, output int at);
        at = -1;
        while (n < limit) begin
            step();
            if (cop_timeout) begin
                at = n;
                return;
            end
        end
    endtask

    function automatic int exp_after_svc(input int e);
        int low;
        low = e % (1 << KEEP_W);
        return e + (PERIOD - low) + ((1 << COP_W) - 1) * PERIOD;
    endfunction

    initial begin
        int at;
        // R10: reset state
        do_reset();
        check(cop_timeout == 1'b0, "R10 reset output", cop_timeout, 0);

        // R4 + R5: free run
        wait_pulse(FULL + 10, at);
        check(at == FULL, "R4 first timeout edge", at, FULL);
        step();
        check(cop_timeout == 1'b0, "R5 pulse width", cop_timeout, 0);
        wait_pulse(2 * FULL + 10, at);
        check(at == 2 * FULL, "R5 second timeout edge", at, 2 * FULL);

        // R1 R2 R3: vector table
        for (int i = 0; i < NV; i++) begin
            int e;
            int exp;
            logic [40:0] v;
            v = VEC[i];
            e = int'(v[15:0]);
            do_reset();
            write_at(e, v[40], v[39:24], v[23:16]);
            if (v[40] && v[39:24] == SVC)
                exp = exp_after_svc(e);
            else
                exp = FULL;
            wait_pulse(2 * FULL, at);
            if (v[40] && v[39:24] == SVC)
                check(at == exp, "R1 R2 service timing", at, exp);
            else
                check(at == exp, "R3 ignored write", at, exp);
        end

        // R9: service on the overflow edge
        do_reset();
        write_at(FULL, 1'b1, SVC, 8'h5A);
        check(cop_timeout == 1'b0, "R9 no pulse on collision", cop_timeout, 0);
        wait_pulse(3 * FULL, at);
        check(at == exp_after_svc(FULL), "R9 restart after collision", at, exp_after_svc(FULL));

        // R6: monitor mode with interrupt-pin flag
        do_reset();
        mon_mode = 1'b1; hv_irq = 1'b1;
        wait_pulse(FULL + 50, at);
        check(at == -1, "R6 monitor+irq suppresses", at, -1);
        mon_mode = 1'b0; hv_irq = 1'b0;
        wait_pulse(3 * FULL, at);
        check(at == 2 * FULL, "R6 counting continued", at, 2 * FULL);

        // R6: monitor mode with reset-pin flag
        do_reset();
        mon_mode = 1'b1; hv_rst = 1'b1;
        wait_pulse(FULL + 50, at);
        check(at == -1, "R6 monitor+rst suppresses", at, -1);
        mon_mode = 1'b0; hv_rst = 1'b0;

        // R7: monitor alone does not disable
        do_reset();
        mon_mode = 1'b1;
        wait_pulse(FULL + 10, at);
        check(at == FULL, "R7 monitor without flag", at, FULL);
        mon_mode = 1'b0;

        // R7: break with reset-pin flag disables
        do_reset();
        brk_state = 1'b1; hv_rst = 1'b1;
        wait_pulse(FULL + 50, at);
        check(at == -1, "R7 break+rst suppresses", at, -1);
        brk_state = 1'b0; hv_rst = 1'b0;
        wait_pulse(3 * FULL, at);
        check(at == 2 * FULL, "R7 resume after break", at, 2 * FULL);

        // R7: break with interrupt-pin flag does not disable
        do_reset();
        brk_state = 1'b1; hv_irq = 1'b1;
        wait_pulse(FULL + 10, at);
        check(at == FULL, "R7 break+irq not disabled", at, FULL);
        brk_state = 1'b0; hv_irq = 1'b0;

        // R8: disable only in the overflow cycle
        do_reset();
        while (n < FULL - 1) step();
        mon_mode = 1'b1; hv_rst = 1'b1;
        step();
        check(cop_timeout == 1'b0, "R8 one-cycle disable", cop_timeout, 0);
        mon_mode = 1'b0; hv_rst = 1'b0;
        wait_pulse(3 * FULL, at);
        check(at == 2 * FULL, "R8 next overflow", at, 2 * FULL);

        // R8: disable removed before overflow leaves no trace
        do_reset();
        while (n < FULL - 20) step();
        brk_state = 1'b1; hv_rst = 1'b1;
        while (n < FULL - 3) step();
        brk_state = 1'b0; hv_rst = 1'b0;
        wait_pulse(FULL + 10, at);
        check(at == FULL, "R8 no stored disable", at, FULL);

        // R10: reset mid-count restarts interval
        do_reset();
        while (n < 300) step();
        do_reset();
        wait_pulse(FULL + 10, at);
        check(at == FULL, "R10 mid-count reset", at, FULL);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule